// File: doc/BRIEF.md
# DDR read-return valid timer

This block sits on the PHY side of a DDR read path and tells the memory controller when a captured read burst may be consumed. Each read command is stamped with a deadline. The deadline is the issue time plus a programmable read latency, which marks when the first beat should arrive, plus a programmable settle delay. The settle delay absorbs board flight time, the pin-to-FIFO path, the quarter-cycle strobe shift used for capture, and any offset between the PHY and controller clocks. When the deadline arrives, the block raises a valid strobe for one burst.

Capture logic on the strobe side writes each rising-edge and falling-edge data pair into a small read FIFO as one wide word. The controller side pops one paired word per valid cycle, on rising edges of the master clock only. Up to four reads may be outstanding at once. Each read produces its own four-cycle valid window, and the windows come out in issue order. Raising the settle delay moves the valid windows later and leaves the returned data unchanged.

Top module: `ddr_rd_valid_timer`

## Requirements
- R1: While reset is held and right after it is released, `rd_valid_o`, `pend_full_o` and `cap_ovf_o` are all 0.
- R2: A read command sampled at clock edge E makes `rd_valid_o` first high after edge E + L + D. Here L is `rd_lat_i` and D is the effective settle delay, both sampled at edge E. This holds when no earlier burst is still in progress.
- R3: Each accepted read holds `rd_valid_o` high for exactly 4 consecutive cycles.
- R4: A settle delay of 0 on `rd_dly_i` is treated as 1. Every other value from 1 to 15 is used as given.
- R5: A capture write stores the word {`cap_fall_i`, `cap_rise_i`}, with the rising-edge half in the low DQ_W bits. While `rd_valid_o` is high, `rd_data_o` shows the oldest stored word, and that word is removed at the next edge. Words leave in the order they were written.
- R6: Bursts come out in command order. If a burst's deadline falls while an earlier burst is still in progress, it starts in the cycle right after that burst's last beat.
- R7: `pend_full_o` is 1 while 4 reads are waiting to start. A read command sampled while it is 1 is ignored and produces no valid window.
- R8: A capture write while the read FIFO holds 8 words is discarded and sets `cap_ovf_o`, which stays 1 until reset.
- R9: Changing the settle delay shifts the valid window by the same number of cycles and does not change the data presented.
- R10: Reset clears pending reads, FIFO contents and the overflow flag. Reads issued before the reset produce no valid window afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all transfers on rising edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_cmd_i | input | 1 | Read command issued this cycle |
| rd_lat_i | input | 5 | Read latency in cycles, sampled with the command |
| rd_dly_i | input | 4 | Settle delay in cycles, sampled with the command (reset-time setting 4) |
| cap_we_i | input | 1 | Capture write of one data pair into the read FIFO |
| cap_rise_i | input | DQ_W | Data captured on the rising strobe edge |
| cap_fall_i | input | DQ_W | Data captured on the falling strobe edge |
| rd_valid_o | output | 1 | Paired read data valid to the controller |
| rd_data_o | output | 2*DQ_W | Paired word {fall, rise} |
| pend_full_o | output | 1 | Four reads are pending |
| cap_ovf_o | output | 1 | Sticky read FIFO overflow |

## Verification
The hardest case to reach is a pending queue that is full while a further command arrives. Doing this needs four reads in flight with their deadlines still ahead, plus a fifth command before any burst has started. The bench sets a long latency, issues five commands on consecutive cycles, and expects exactly four bursts at serialized times. Bursts whose deadlines collide are reached in a similar way, with commands on adjacent cycles and a short delay, so that each later burst is deferred to the end of the one before it.

// File: rtl/ddr_rdv_pkg.sv
package ddr_rdv_pkg;
  localparam int RL_W        = 5;
  localparam int DLY_W       = 4;
  localparam int TS_W        = 8;
  localparam int BURST_PAIRS = 4;

  typedef logic [RL_W-1:0]  rl_t;
  typedef logic [DLY_W-1:0] dly_t;
  typedef logic [TS_W-1:0]  ts_t;

  function automatic dly_t dly_clamp(dly_t d);
    return (d == '0) ? dly_t'(1) : d;
  endfunction

  // true once now has reached or passed due (wrap-safe)
  function automatic logic ts_reached(ts_t now, ts_t due);
    ts_t diff;
    diff = now - due;
    return !diff[TS_W-1];
  endfunction
endpackage

// File: rtl/rdv_fifo.sv
module rdv_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_C = (AW+1)'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == FULL_C);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == LAST_P) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == LAST_P) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> $stable(cnt_q) && $stable(wptr_q)); // R8
  AST_POP_EMPTY_HARMLESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> $stable(rptr_q) && empty_o); // R5
endmodule

// File: rtl/rdv_beat_gen.sv
module rdv_beat_gen
  import ddr_rdv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic head_vld_i,
  input  ts_t  head_due_i,
  input  ts_t  now_i,
  output logic start_o,
  output logic valid_o
);
  localparam int BW = (BURST_PAIRS > 1) ? $clog2(BURST_PAIRS) : 1;
  localparam logic [BW-1:0] LAST_B = BW'(BURST_PAIRS - 1);

  logic          valid_q;
  logic [BW-1:0] beat_q;

  // next burst may follow the last beat of the current one with no gap
  assign start_o = head_vld_i && ts_reached(now_i, head_due_i)
                   && (!valid_q || beat_q == LAST_B);
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (start_o) begin
      valid_q <= 1'b1;
      beat_q  <= '0;
    end else if (valid_q) begin
      if (beat_q == LAST_B) valid_q <= 1'b0;
      else                  beat_q  <= beat_q + 1'b1;
    end
  end

  AST_BURST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && beat_q != LAST_B |=> valid_q); // R3
  AST_START_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(head_vld_i)); // R6
endmodule

// File: rtl/ddr_rd_valid_timer.sv
module ddr_rd_valid_timer
  import ddr_rdv_pkg::*;
#(
  parameter int DQ_W       = 16,
  parameter int PEND_DEPTH = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_cmd_i,
  input  logic [RL_W-1:0]   rd_lat_i,
  input  logic [DLY_W-1:0]  rd_dly_i,
  input  logic              cap_we_i,
  input  logic [DQ_W-1:0]   cap_rise_i,
  input  logic [DQ_W-1:0]   cap_fall_i,
  output logic              rd_valid_o,
  output logic [2*DQ_W-1:0] rd_data_o,
  output logic              pend_full_o,
  output logic              cap_ovf_o
);
  localparam int PW = 2 * DQ_W;

  ts_t  ts_q, due_d, head_due;
  logic head_empty, start, valid;
  logic dat_full, dat_empty, ovf_q;

  assign due_d = ts_q + ts_t'(rd_lat_i) + ts_t'(dly_clamp(rd_dly_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (cap_we_i && dat_full) ovf_q <= 1'b1;
    end
  end

  rdv_fifo #(.W(TS_W), .DEPTH(PEND_DEPTH)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rd_cmd_i),
    .wdata_i (due_d),
    .pop_i   (start),
    .rdata_o (head_due),
    .full_o  (pend_full_o),
    .empty_o (head_empty)
  );

  rdv_beat_gen u_beat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_vld_i (!head_empty),
    .head_due_i (head_due),
    .now_i      (ts_q),
    .start_o    (start),
    .valid_o    (valid)
  );

  rdv_fifo #(.W(PW), .DEPTH(FIFO_DEPTH)) u_rdata (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cap_we_i),
    .wdata_i ({cap_fall_i, cap_rise_i}),
    .pop_i   (valid && !dat_empty),
    .rdata_o (rd_data_o),
    .full_o  (dat_full),
    .empty_o (dat_empty)
  );

  assign rd_valid_o = valid;
  assign cap_ovf_o  = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ovf_o |=> cap_ovf_o); // R8
  AST_FULL_CMD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_full_o && rd_cmd_i && !start |=> pend_full_o); // R7
  AST_VALID_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(!head_empty)); // R2
endmodule

// File: tb/tb_ddr_rd_valid_timer.sv
module tb_ddr_rd_valid_timer;
  localparam int DQ_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_cmd = 1'b0, cap_we = 1'b0;
  logic [4:0] rd_lat = '0;
  logic [3:0] rd_dly = 4'd4;
  logic [DQ_W-1:0] cap_rise = '0, cap_fall = '0;
  logic rd_valid, pend_full, cap_ovf;
  logic [2*DQ_W-1:0] rd_data;

  int cyc = 0, errs = 0, checks = 0, next_free = 0;

  typedef struct { int at; logic [2*DQ_W-1:0] data; bit chk; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_rd_valid_timer #(.DQ_W(DQ_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_cmd_i(rd_cmd), .rd_lat_i(rd_lat),
    .rd_dly_i(rd_dly), .cap_we_i(cap_we), .cap_rise_i(cap_rise),
    .cap_fall_i(cap_fall), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .pend_full_o(pend_full), .cap_ovf_o(cap_ovf)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [2*DQ_W-1:0] pat(int tag, int b);
    logic [DQ_W-1:0] r, f;
    r = DQ_W'(tag * 16 + b);
    f = ~DQ_W'(tag * 32 + b * 3);
    return {f, r};
  endfunction

  // driver: one read, optionally with its four capture writes
  task automatic issue(int rl, int d, bit with_data, int tag);
    int e0, st, deff;
    @(negedge clk);
    rd_lat = 5'(rl); rd_dly = 4'(d); rd_cmd = 1'b1; cap_we = 1'b0;
    e0 = cyc + 1;
    deff = (d == 0) ? 1 : d;
    st = e0 + rl + deff;
    if (st < next_free) st = next_free;
    next_free = st + 4;
    for (int b = 0; b < 4; b++) begin
      exp_t e;
      e.at = st + b; e.data = pat(tag, b); e.chk = with_data;
      sb.push_back(e);
    end
    if (with_data) begin
      for (int b = 0; b < 4; b++) begin
        if (b > 0) begin @(negedge clk); rd_cmd = 1'b0; end
        cap_we = 1'b1; {cap_fall, cap_rise} = pat(tag, b);
      end
    end
  endtask

  task automatic idle(int n);
    @(negedge clk); rd_cmd = 1'b0; cap_we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each valid beat with the scoreboard head
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (sb.size() == 0) check(0, "R3/R6 unexpected valid", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.at, "R2/R6 valid timing", cyc, e.at);
          if (e.chk) check(rd_data == e.data, "R5/R9 paired data", rd_data, e.data);
        end
      end else if (sb.size() != 0 && sb[0].at <= cyc) begin
        check(0, "R3 missing valid beat", 0, sb[0].at);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rd_valid && !pend_full && !cap_ovf, "R1 in reset", {rd_valid, pend_full, cap_ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_valid && !pend_full && !cap_ovf, "R1 after reset", {rd_valid, pend_full, cap_ovf}, 0);

    // R2 basic latency with data (R5)
    issue(3, 4, 1, 1); idle(20);
    check(sb.size() == 0, "R3 burst complete", sb.size(), 0);
    // R9 one more cycle of delay, same data
    issue(3, 5, 1, 1); idle(20);
    // R4 zero delay clamped to one
    issue(2, 0, 1, 2); idle(15);
    // R6 two data reads back to back
    issue(1, 4, 1, 3); issue(1, 4, 1, 4); idle(20);
    // R6 colliding deadlines get serialized
    issue(1, 1, 0, 0); issue(1, 1, 0, 0); issue(1, 1, 0, 0); idle(25);
    check(sb.size() == 0, "R6 all bursts served", sb.size(), 0);

    // R7 four pending, fifth ignored
    for (int i = 0; i < 4; i++) issue(20, 4, 0, 0);
    @(negedge clk);
    check(pend_full == 1'b1, "R7 pend full", pend_full, 1);
    rd_cmd = 1'b1;
    idle(60);
    check(pend_full == 1'b0, "R7 pend drained", pend_full, 0);
    check(sb.size() == 0, "R7 four bursts only", sb.size(), 0);

    // R8 overflow on ninth capture write
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); cap_we = 1'b1; {cap_fall, cap_rise} = pat(9, i);
    end
    @(negedge clk); cap_we = 1'b0;
    check(cap_ovf == 1'b0, "R8 no overflow at 8", cap_ovf, 0);
    cap_we = 1'b1;
    @(negedge clk); cap_we = 1'b0;
    check(cap_ovf == 1'b1, "R8 overflow set", cap_ovf, 1);
    repeat (3) @(negedge clk);
    check(cap_ovf == 1'b1, "R8 overflow sticky", cap_ovf, 1);

    // R10 reset with a read pending and stale FIFO words
    issue(10, 4, 0, 0); idle(3);
    rst_n = 1'b0; sb.delete(); next_free = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cap_ovf && !pend_full && !rd_valid, "R10 cleared", {cap_ovf, pend_full, rd_valid}, 0);
    idle(30);
    issue(2, 4, 1, 5); idle(20);
    check(sb.size() == 0, "R10 fresh read served", sb.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule